// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block is the receive side of a stereo or four-slot audio serial link when another device drives the clocks. The bit clock, the frame clock and the data line enter asynchronously. They are oversampled in the system clock domain, which must run at least four times faster than the bit clock. Bits are taken on rising bit-clock edges. Each completed channel or slot is delivered as a 24-bit two's complement word, together with a channel index and a one-cycle valid strobe.

Static configuration inputs set the behaviour. They choose one of five framing styles: a standard two-channel format that starts on a falling frame-clock edge, left-aligned, right-aligned, four-slot time-division with a square frame clock, and four-slot time-division with a one-bit frame pulse. Further inputs invert the frame-clock edge sense, set how many bit clocks to skip at the start of each slot, and set the word length for the right-aligned format. The two-channel formats track the frame-clock edges, so each half may have any length. The four-slot formats split each frame into quarters, and the quarter length is measured from the previous frame.

Top module: `aud_serial_rx`

## Requirements
- R1: Bits are taken on rising edges of `bclk_i` after a two-stage synchronizer. Each completed channel or slot produces exactly one `valid_o` pulse lasting one system clock, with `word_o` and `chan_o` valid in that cycle.
- R2: With `fmt_i`=0 and `lr_invert_i`=0, a falling edge of `lrclk_i` starts a frame. The half that follows is channel 0 (left, `lrclk_i` low). The half after the rising edge is channel 1 (right). Channel 0 is always delivered before channel 1.
- R3: With `fmt_i`=1 and `lr_invert_i`=0, a rising edge starts the frame. Channel 0 is the half in which `lrclk_i` is high.
- R4: With `fmt_i`=2 (rising edge starts the frame), the word is the last W bits of each half. W is set by `rj_len_i`: 0 gives 24, 1 gives 20, 2 gives 18, 3 gives 16. The first of those bits lands in bit 23, the low 24-W bits are zero, and `data_dly_i` has no effect.
- R5: With `fmt_i`=3, a falling edge starts the frame. The frame is cut into four slots of L/4 bits each, where L is the number of bit clocks in the previous frame. Slots are delivered with `chan_o` 0, 1, 2, 3 in order. The frame that follows the first frame start after reset delivers no words.
- R6: With `fmt_i`=4, the frame clock is a one-bit-wide pulse and its rising edge starts the frame. Slots are cut and numbered as in R5.
- R7: `lr_invert_i`=1 swaps the frame-starting edge of every format, and with it the `lrclk_i` level that carries channel 0.
- R8: Except in `fmt_i`=2, the first 24 bits after the skipped bits are placed MSB first from bit 23 downward. Further bits in the slot are dropped. If the slot ends sooner, the unfilled low bits are zero.
- R9: Except in `fmt_i`=2, the first `data_dly_i` (0 to 31) bit clocks of every channel or slot are skipped before data capture begins.
- R10: While `rst_ni` is low, `valid_o`, `word_o` and `chan_o` are zero. No word is delivered for bits that arrive before the first frame-starting edge after reset.
- R11: In the two-channel formats, consecutive frames and halves may differ in length. Each half is cut at the frame-clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External frame clock (square or pulse) |
| sdata_i | input | 1 | Serial data, changes on falling bit-clock edges |
| fmt_i | input | 3 | Framing style, codes 0 to 4 as in R2 to R6 |
| lr_invert_i | input | 1 | Swap the frame-starting edge |
| data_dly_i | input | 5 | Bit clocks skipped at each slot start |
| rj_len_i | input | 2 | Word length for the right-aligned format |
| word_o | output | 24 | Received sample, left-aligned two's complement |
| chan_o | output | 2 | Channel or slot index of `word_o` |
| valid_o | output | 1 | One-cycle strobe for `word_o` and `chan_o` |

## Verification
The assertions check several properties on every cycle. A valid strobe never lasts more than one cycle and always follows a synchronized bit-clock edge. The channel index alternates in two-channel formats, stays below 2 there, and steps 0 to 3 cyclically in the four-slot formats. Short right-aligned words always have zero low bits. Only the bench scenarios can show the rest: that the right bits land in the right word under each edge sense, delay, word length and slot length; that extra bits are dropped and short slots zero-filled; and that nothing appears during the measuring frame or before the first frame start.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [2:0] {
        FMT_STD       = 3'd0,
        FMT_LEFT      = 3'd1,
        FMT_RIGHT     = 3'd2,
        FMT_TDM_SQ    = 3'd3,
        FMT_TDM_PULSE = 3'd4
    } fmt_e;

    // Frame-starting edge before inversion: 1 = rising, 0 = falling.
    function automatic logic starts_on_rise(input fmt_e f);
        case (f)
            FMT_STD, FMT_TDM_SQ: return 1'b0;
            default:             return 1'b1;
        endcase
    endfunction

    function automatic logic slot_format(input fmt_e f);
        return (f == FMT_TDM_SQ) || (f == FMT_TDM_PULSE);
    endfunction

    function automatic logic [5:0] right_width(input logic [1:0] sel);
        case (sel)
            2'd0:    return 6'd24;
            2'd1:    return 6'd20;
            2'd2:    return 6'd18;
            default: return 6'd16;
        endcase
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic sdata_i,
    output logic bit_stb_o,
    output logic lr_o,
    output logic sd_o
);

    typedef struct packed {
        logic [STAGES-1:0] bclk;
        logic [STAGES-1:0] lr;
        logic [STAGES-1:0] sd;
        logic              bclk_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d           = sync_q;
        sync_d.bclk      = {sync_q.bclk[STAGES-2:0], bclk_i};
        sync_d.lr        = {sync_q.lr[STAGES-2:0], lrclk_i};
        sync_d.sd        = {sync_q.sd[STAGES-2:0], sdata_i};
        sync_d.bclk_prev = sync_q.bclk[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign bit_stb_o = sync_q.bclk[STAGES-1] & ~sync_q.bclk_prev;
    assign lr_o      = sync_q.lr[STAGES-1];
    assign sd_o      = sync_q.sd[STAGES-1];

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       bit_stb_i,
    input  logic       lr_i,
    input  fmt_e       fmt_i,
    input  logic       lr_invert_i,
    output logic       bound_o,
    output logic       emit_o,
    output logic [1:0] slot_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             primed;
        logic             lr_prev;
        logic             locked;
        logic             len_ok;
        logic [CNT_W-1:0] bitcnt;
        logic [CNT_W-1:0] frame_len;
        logic [1:0]       slot;
    } frm_t;

    frm_t frm_d, frm_q;

    logic             on_rise, tdm, rise, fall, lead, mid;
    logic [CNT_W-1:0] quarter, next_idx;
    logic [CNT_W+1:0] thresh;

    always_comb begin
        frm_d    = frm_q;
        bound_o  = 1'b0;
        emit_o   = 1'b0;
        slot_o   = frm_q.slot;

        on_rise  = starts_on_rise(fmt_i) ^ lr_invert_i;
        tdm      = slot_format(fmt_i);
        rise     = frm_q.primed & lr_i & ~frm_q.lr_prev;
        fall     = frm_q.primed & ~lr_i & frm_q.lr_prev;
        lead     = on_rise ? rise : fall;
        mid      = on_rise ? fall : rise;
        quarter  = frm_q.frame_len >> 2;
        next_idx = (frm_q.bitcnt == CNT_MAX) ? frm_q.bitcnt : frm_q.bitcnt + 1'b1;

        case (frm_q.slot)
            2'd0:    thresh = {2'b00, quarter};
            2'd1:    thresh = {1'b0, quarter, 1'b0};
            default: thresh = {2'b00, quarter} + {1'b0, quarter, 1'b0};
        endcase

        if (bit_stb_i) begin
            frm_d.primed  = 1'b1;
            frm_d.lr_prev = lr_i;
            frm_d.bitcnt  = next_idx;
            if (lead) begin
                bound_o         = 1'b1;
                emit_o          = frm_q.locked & (~tdm | frm_q.len_ok);
                frm_d.locked    = 1'b1;
                frm_d.len_ok    = frm_q.locked & tdm;
                frm_d.frame_len = next_idx;
                frm_d.bitcnt    = '0;
                frm_d.slot      = 2'd0;
            end else if (!tdm && mid && frm_q.locked && frm_q.slot == 2'd0) begin
                bound_o    = 1'b1;
                emit_o     = 1'b1;
                frm_d.slot = 2'd1;
            end else if (tdm && frm_q.len_ok && frm_q.slot != 2'd3 &&
                         {2'b00, next_idx} == thresh) begin
                bound_o    = 1'b1;
                emit_o     = 1'b1;
                frm_d.slot = frm_q.slot + 2'd1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

endmodule

// File: rtl/aud_rx_assemble.sv
module aud_rx_assemble
    import aud_rx_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_stb_i,
    input  logic              sd_i,
    input  logic              bound_i,
    input  logic              emit_i,
    input  logic [1:0]        slot_i,
    input  fmt_e              fmt_i,
    input  logic [4:0]        data_dly_i,
    input  logic [1:0]        rj_len_i,
    output logic [WORD_W-1:0] word_o,
    output logic [1:0]        chan_o,
    output logic              valid_o
);

    localparam int               IDX_W   = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] WLIM    = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] shr;
        logic [CNT_W-1:0]  pos;
        logic [WORD_W-1:0] word;
        logic [1:0]        chan;
        logic              valid;
    } asm_t;

    asm_t asm_d, asm_q;

    logic [5:0]        rj_w, rj_shift;
    logic [WORD_W-1:0] rj_mask, rj_word, acc_base, shr_base;
    logic [CNT_W-1:0]  pos_base, dly, rel, idx_full;
    logic [IDX_W-1:0]  bit_idx;

    always_comb begin
        asm_d       = asm_q;
        asm_d.valid = 1'b0;

        rj_w     = right_width(rj_len_i);
        rj_shift = 6'(WORD_W) - rj_w;
        rj_mask  = ~({WORD_W{1'b1}} << rj_w);
        rj_word  = (asm_q.shr & rj_mask) << rj_shift;

        pos_base = bound_i ? '0 : asm_q.pos;
        acc_base = bound_i ? '0 : asm_q.acc;
        shr_base = bound_i ? '0 : asm_q.shr;
        dly      = CNT_W'(data_dly_i);
        rel      = pos_base - dly;
        idx_full = TOP_BIT - rel;
        bit_idx  = idx_full[IDX_W-1:0];

        if (bit_stb_i) begin
            if (bound_i && emit_i) begin
                asm_d.word  = (fmt_i == FMT_RIGHT) ? rj_word : asm_q.acc;
                asm_d.chan  = slot_i;
                asm_d.valid = 1'b1;
            end
            if (pos_base >= dly && rel < WLIM) begin
                acc_base[bit_idx] = sd_i;
            end
            asm_d.acc = acc_base;
            asm_d.shr = {shr_base[WORD_W-2:0], sd_i};
            asm_d.pos = (pos_base == CNT_MAX) ? pos_base : pos_base + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign word_o  = asm_q.word;
    assign chan_o  = asm_q.chan;
    assign valid_o = asm_q.valid;

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bclk_i,
    input  logic              lrclk_i,
    input  logic              sdata_i,
    input  logic [2:0]        fmt_i,
    input  logic              lr_invert_i,
    input  logic [4:0]        data_dly_i,
    input  logic [1:0]        rj_len_i,
    output logic [WORD_W-1:0] word_o,
    output logic [1:0]        chan_o,
    output logic              valid_o
);

    fmt_e       fmt;
    logic       bit_stb, lr_s, sd_s, bound, emit;
    logic [1:0] slot;

    assign fmt = fmt_e'(fmt_i);

    aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .bclk_i    (bclk_i),
        .lrclk_i   (lrclk_i),
        .sdata_i   (sdata_i),
        .bit_stb_o (bit_stb),
        .lr_o      (lr_s),
        .sd_o      (sd_s)
    );

    aud_rx_framer #(.CNT_W(CNT_W)) u_framer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bit_stb_i   (bit_stb),
        .lr_i        (lr_s),
        .fmt_i       (fmt),
        .lr_invert_i (lr_invert_i),
        .bound_o     (bound),
        .emit_o      (emit),
        .slot_o      (slot)
    );

    aud_rx_assemble #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_assemble (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bit_stb_i  (bit_stb),
        .sd_i       (sd_s),
        .bound_i    (bound),
        .emit_i     (emit),
        .slot_i     (slot),
        .fmt_i      (fmt),
        .data_dly_i (data_dly_i),
        .rj_len_i   (rj_len_i),
        .word_o     (word_o),
        .chan_o     (chan_o),
        .valid_o    (valid_o)
    );

endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
    parameter int WORD_W = 24
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bit_stb,
    input logic [2:0]        fmt_i,
    input logic [1:0]        rj_len_i,
    input logic [WORD_W-1:0] word_o,
    input logic [1:0]        chan_o,
    input logic              valid_o
);

    logic [1:0] last_chan_q;
    logic       seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            last_chan_q <= 2'd0;
            seen_q      <= 1'b0;
        end else if (valid_o) begin
            last_chan_q <= chan_o;
            seen_q      <= 1'b1;
        end
    end

    // R1
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R1
    after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(bit_stb));

    // R2
    stereo_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && fmt_i < 3'd3) |-> (chan_o < 2'd2));

    // R2
    stereo_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && seen_q && fmt_i < 3'd3) |-> (chan_o[0] != last_chan_q[0]));

    // R5
    slot_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && seen_q && (fmt_i == 3'd3 || fmt_i == 3'd4)) |->
        (chan_o == 2'(last_chan_q + 2'd1)));

    // R4
    rj16_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && fmt_i == 3'd2 && rj_len_i == 2'd3) |-> (word_o[7:0] == 8'd0));

    // R4
    rj20_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && fmt_i == 3'd2 && rj_len_i == 2'd1) |-> (word_o[3:0] == 4'd0));

endmodule

bind aud_serial_rx aud_serial_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_stb  (bit_stb),
    .fmt_i    (fmt_i),
    .rj_len_i (rj_len_i),
    .word_o   (word_o),
    .chan_o   (chan_o),
    .valid_o  (valid_o)
);

// File: tb/aud_serial_rx_bench.sv
module aud_serial_rx_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bclk = 1'b1, lrclk = 1'b0, sdata = 1'b0;
    logic [2:0]  fmt = 3'd0;
    logic        inv = 1'b0;
    logic [4:0]  dly = 5'd0;
    logic [1:0]  rjl = 2'd0;
    logic [23:0] word;
    logic [1:0]  chan;
    logic        valid;

    aud_serial_rx u_aud_serial_rx (
        .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
        .fmt_i(fmt), .lr_invert_i(inv), .data_dly_i(dly), .rj_len_i(rjl),
        .word_o(word), .chan_o(chan), .valid_o(valid)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [23:0] exp_w[$];
    logic [1:0]  exp_c[$];
    string       exp_t[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    logic [23:0] mon_w;
    logic [1:0]  mon_c;
    string       mon_t;
    always @(negedge clk) begin
        if (rst_n && valid === 1'b1) begin
            if (exp_w.size() == 0) begin
                check("R10", 32'd1, 32'd0, "unexpected word");
            end else begin
                mon_w = exp_w.pop_front();
                mon_c = exp_c.pop_front();
                mon_t = exp_t.pop_front();
                check(mon_t, {30'd0, chan}, {30'd0, mon_c}, "channel");
                check(mon_t, {8'd0, word}, {8'd0, mon_w}, "word");
            end
        end
    end

    function automatic logic [23:0] exp_word(input logic [31:0] src, input int len);
        if (len >= 24) return 24'(src >> (len - 24));
        else           return 24'(src << (24 - len));
    endfunction

    task automatic push(input string tag, input logic [1:0] c, input logic [23:0] w);
        exp_w.push_back(w);
        exp_c.push_back(c);
        exp_t.push_back(tag);
    endtask

    task automatic send_bit(input logic lr, input logic sd);
        @(negedge clk);
        bclk  = 1'b0;
        lrclk = lr;
        sdata = sd;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Filler bits are 1 so that skipped or masked positions would show up.
    task automatic send_slot(input logic lr0, input logic lr, input int n, input int d,
                             input int len, input logic [31:0] src, input bit rj);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = 1'b1;
            if (rj) begin
                if (i >= n - len) b = src[len - 1 - (i - (n - len))];
            end else if (i >= d && i < d + len) begin
                b = src[len - 1 - (i - d)];
            end
            send_bit(i == 0 ? lr0 : lr, b);
        end
    endtask

    task automatic do_reset(input logic [2:0] f, input logic iv, input logic [4:0] dd,
                            input logic [1:0] rl, input logic idle_lr);
        rst_n = 1'b0;
        fmt   = f;
        inv   = iv;
        dly   = dd;
        rjl   = rl;
        bclk  = 1'b1;
        lrclk = idle_lr;
        sdata = 1'b1;
        repeat (4) @(negedge clk);
        check("R10", {31'd0, valid}, 32'd0, "valid in reset");
        check("R10", {8'd0, word}, 32'd0, "word in reset");
        check("R10", {30'd0, chan}, 32'd0, "chan in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        repeat (24) @(negedge clk);
        check(tag, exp_w.size(), 32'd0, "words outstanding");
        exp_w.delete();
        exp_c.delete();
        exp_t.delete();
    endtask

    typedef struct packed {
        logic [2:0]  fmt;
        logic        inv;
        logic [4:0]  dly;
        logic [1:0]  rjl;
        logic [5:0]  n;
        logic [5:0]  len;
        logic [31:0] wl;
        logic [31:0] wr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 5'd1, 2'd0, 6'd32, 6'd24, 32'h123456,  32'hABCDEF,  4'd2}, // R2
        '{3'd1, 1'b0, 5'd0, 2'd0, 6'd32, 6'd24, 32'h7FFFFF,  32'h800000,  4'd3}, // R3
        '{3'd2, 1'b0, 5'd7, 2'd0, 6'd32, 6'd24, 32'h5A5A5A,  32'hC3C3C3,  4'd4}, // R4 w24
        '{3'd2, 1'b0, 5'd0, 2'd1, 6'd32, 6'd20, 32'h81234,   32'h7EDCB,   4'd4}, // R4 w20
        '{3'd2, 1'b0, 5'd3, 2'd3, 6'd24, 6'd16, 32'h8001,    32'h1234,    4'd4}, // R4 w16
        '{3'd1, 1'b0, 5'd0, 2'd0, 6'd32, 6'd28, 32'hABCDEF5, 32'h1234567, 4'd8}, // R8 drop
        '{3'd1, 1'b0, 5'd0, 2'd0, 6'd16, 6'd16, 32'hBEEF,    32'h0102,    4'd8}, // R8 fill
        '{3'd0, 1'b1, 5'd1, 2'd0, 6'd32, 6'd24, 32'h3C3C3C,  32'h900009,  4'd7}, // R7
        '{3'd1, 1'b0, 5'd8, 2'd0, 6'd32, 6'd24, 32'h0F0F0F,  32'hF0F0F0,  4'd9}, // R9
        '{3'd0, 1'b0, 5'd3, 2'd0, 6'd30, 6'd24, 32'h600DAD,  32'hFACADE,  4'd9}  // R9
    };

    task automatic run_vec(input vec_t v);
        string tag;
        logic  left_lr;
        bit    rj;
        tag     = $sformatf("R%0d", v.req);
        rj      = (v.fmt == 3'd2);
        left_lr = ((v.fmt == 3'd0) ? 1'b0 : 1'b1) ^ v.inv;
        do_reset(v.fmt, v.inv, v.dly, v.rjl, ~left_lr);
        for (int i = 0; i < 4; i++) send_bit(~left_lr, 1'b1);
        for (int f = 0; f < 2; f++) begin
            push(tag, 2'd0, exp_word(v.wl, int'(v.len)));
            send_slot(left_lr, left_lr, int'(v.n), int'(v.dly), int'(v.len), v.wl, rj);
            push(tag, 2'd1, exp_word(v.wr, int'(v.len)));
            send_slot(~left_lr, ~left_lr, int'(v.n), int'(v.dly), int'(v.len), v.wr, rj);
        end
        for (int i = 0; i < 4; i++) send_bit(left_lr, 1'b0);
        drain(tag);
    endtask

    // R5 / R6: four-slot frames of 128 bit clocks, one-bit delay.
    task automatic run_tdm(input bit pulse);
        string tag;
        logic  idle;
        tag  = pulse ? "R6" : "R5";
        idle = pulse ? 1'b0 : 1'b1;
        do_reset(pulse ? 3'd4 : 3'd3, 1'b0, 5'd1, 2'd0, idle);
        for (int i = 0; i < 4; i++) send_bit(idle, 1'b1);
        for (int f = 0; f < 3; f++) begin
            for (int s = 0; s < 4; s++) begin
                logic [31:0] src;
                logic        l0, lr;
                src = 32'hA00000 ^ (s << 12) ^ (f << 4) ^ s;
                if (pulse) begin
                    l0 = (s == 0);
                    lr = 1'b0;
                end else begin
                    l0 = (s >= 2);
                    lr = (s >= 2);
                end
                if (f > 0) push(tag, 2'(s), exp_word(src, 24));
                send_slot(l0, lr, 32, 1, 24, src, 1'b0);
            end
        end
        for (int i = 0; i < 4; i++) send_bit(pulse ? (i == 0) : 1'b0, 1'b0);
        drain(tag);
    endtask

    // R11: left-aligned frames whose halves change length from frame to frame.
    task automatic run_varying();
        do_reset(3'd1, 1'b0, 5'd0, 2'd0, 1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b1);
        push("R11", 2'd0, 24'h112233);
        send_slot(1'b1, 1'b1, 32, 0, 24, 32'h112233, 1'b0);
        push("R11", 2'd1, 24'h445566);
        send_slot(1'b0, 1'b0, 26, 0, 24, 32'h445566, 1'b0);
        push("R11", 2'd0, 24'hABCDE0);
        send_slot(1'b1, 1'b1, 20, 0, 20, 32'hABCDE, 1'b0);
        push("R11", 2'd1, 24'h987654);
        send_slot(1'b0, 1'b0, 40, 0, 32, 32'h98765432, 1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
        drain("R11");
    endtask

    // R10: frame-clock toggles on the non-starting edge only deliver nothing.
    task automatic run_unlocked();
        do_reset(3'd0, 1'b0, 5'd1, 2'd0, 1'b0);
        for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b1);
        for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
        drain("R10");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);
        run_tdm(1'b0);
        run_tdm(1'b1);
        run_varying();
        run_unlocked();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule